// File: doc/BRIEF.md
# Digital Constant Fraction Discriminator Channel

This block handles a single calorimeter channel. A 12-bit ADC sample enters on every clock. The block removes a per-channel baseline and clamps the result at zero. It then looks for pulses with a digital constant fraction method. It forms a bipolar sequence B[i] = k·A[i] − A[i+N] from a scaled sample and a later sample. A pulse is timed at the sample where B changes from positive to zero or negative.

For each accepted crossing the block produces a one-cycle hit strobe together with three values: a coarse sample index, a 4-bit fractional fine time, and the pulse amplitude. The fine time is found by a pipelined restoring divider. The amplitude is the sample M positions after the crossing, and it must exceed a programmable threshold. The baseline register only takes a new value on a spill-boundary pulse. After each hit, a hold-off window of M samples blocks further hits, so one pulse does not fire twice.

Top module: `cfd_channel`

## Requirements
- R1: The stored sample is A = max(raw − baseline, 0) in ADC counts. A raw sample at or below the active baseline gives A = 0, so a fully clamped stream produces no hits.
- R2: The active baseline is reset to 0. It loads `ped_cfg_i` only at a clock edge where `spill_i` is 1. The sample captured at that same edge still uses the previous baseline. Changing `ped_cfg_i` without a spill pulse has no effect.
- R3: With k = `frac_cfg_i`/16 (4 fractional bits) and N = `dly_cfg_i` (0..7), the block computes B[i] = 16·(k·A[i] − A[i+N]) as a signed 18-bit value. A crossing at index i needs B[i] > 0 and B[i+1] ≤ 0. Two hits never appear on consecutive cycles.
- R4: On a hit, `fine_o` = floor(16·B[i] / (B[i] − B[i+1])), saturated at 15.
- R5: A hit is reported only if A[i+M] > `thr_cfg_i` (strict compare), where M = `ofs_cfg_i` (0..7). On a hit, `amp_o` equals A[i+M].
- R6: After a hit at index i, crossings at indices i+1 through i+M are rejected. M is the offset in force when the hit was accepted.
- R7: Let D = max(N+1, M). The crossing at index i is evaluated once sample i+D has been captured. Its hit strobe appears exactly 5 clock edges after the edge that captured sample i+D: one detection register plus 4 divider stages.
- R8: `coarse_o` = i modulo 2^16. Samples are numbered from 0, starting with the first capture after reset is released.
- R9: No crossing is evaluated until D+1 samples have been captured since reset.
- R10: While `rst_ni` is low, and whenever `hit_o` is 0, the outputs `hit_o`, `coarse_o`, `fine_o` and `amp_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_i | input | 12 | Raw ADC sample, one per clock |
| spill_i | input | 1 | Spill boundary pulse; loads the baseline |
| ped_cfg_i | input | 12 | Baseline value to load at the next spill |
| frac_cfg_i | input | 4 | Fraction k, in sixteenths |
| dly_cfg_i | input | 3 | Delay N, in samples |
| ofs_cfg_i | input | 3 | Amplitude offset M and hold-off length |
| thr_cfg_i | input | 12 | Amplitude threshold |
| hit_o | output | 1 | One-cycle hit strobe |
| coarse_o | output | 16 | Sample index of the crossing |
| fine_o | output | 4 | Fine time, in sixteenths of a sample |
| amp_o | output | 12 | Pulse amplitude A[i+M] |

## Verification
The bench targets four kinds of corner case.

- Baseline timing: a spill pulse and a baseline change arrive together on the same edge. A design that applied the new baseline one sample early, or without a spill, would shift every amplitude and change which crossings pass.
- Evaluation window: configurations where M is larger than N+1 move the window. A design that used the wrong span would report the wrong coarse index and raise the strobe in the wrong cycle. The start-up fill check catches hits produced from history that has not yet been written.
- Divider edge case: crossings where B[i+1] equals zero must saturate the fine time at 15. A divider that does not saturate would wrap to 0.
- Hold-off and counter wrap: closely spaced double pulses catch a hold-off window that is one sample short or long. A run past 65,536 samples catches a coarse counter that does not wrap cleanly.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
    // default widths shared by the channel modules
    localparam int unsigned SMP_W_DEF = 12;   // ADC sample width
    localparam int unsigned KFR_W_DEF = 4;    // fraction bits of k
    localparam int unsigned BIP_W_DEF = 18;   // signed bipolar width
    localparam int unsigned FT_W_DEF  = 4;    // fine time bits, one divider stage each
    localparam int unsigned IDX_W_DEF = 16;   // coarse index width
    localparam int unsigned DLY_W_DEF = 3;    // width of N
    localparam int unsigned OFS_W_DEF = 3;    // width of M

    function automatic int unsigned larger(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cfd_pedestal.sv
module cfd_pedestal #(
    parameter int unsigned SMP_W = cfd_pkg::SMP_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             spill_i,
    input  logic [SMP_W-1:0] ped_cfg_i,
    output logic [SMP_W-1:0] net_o
);
    typedef struct packed {
        logic [SMP_W-1:0] base;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (spill_i) begin
            st_d.base = ped_cfg_i;
        end
        // subtract the active baseline, clamp negative results at zero
        net_o = (smp_i > st_q.base) ? (smp_i - st_q.base) : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // the baseline only moves after an edge that saw a spill pulse
    p_base_spill_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(spill_i) |-> $stable(st_q.base));
endmodule

// File: rtl/cfd_detect.sv
module cfd_detect #(
    parameter int unsigned SMP_W = cfd_pkg::SMP_W_DEF,
    parameter int unsigned KFR_W = cfd_pkg::KFR_W_DEF,
    parameter int unsigned BIP_W = cfd_pkg::BIP_W_DEF,
    parameter int unsigned IDX_W = cfd_pkg::IDX_W_DEF,
    parameter int unsigned DLY_W = cfd_pkg::DLY_W_DEF,
    parameter int unsigned OFS_W = cfd_pkg::OFS_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SMP_W-1:0] a_i,
    input  logic [KFR_W-1:0] frac_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [SMP_W-1:0] thr_i,
    output logic             det_vld_o,
    output logic [BIP_W-1:0] det_num_o,
    output logic [BIP_W-1:0] det_den_o,
    output logic [IDX_W-1:0] det_idx_o,
    output logic [SMP_W-1:0] det_amp_o
);
    localparam int unsigned NMAX   = (1 << DLY_W) - 1;
    localparam int unsigned MMAX   = (1 << OFS_W) - 1;
    localparam int unsigned DMAX   = cfd_pkg::larger(NMAX + 1, MMAX);
    localparam int unsigned HD     = DMAX + 1;               // history depth
    localparam int unsigned IW     = $clog2(HD);             // history index width
    localparam int unsigned FILL_W = IW + 1;

    typedef struct packed {
        logic [HD-1:0][SMP_W-1:0] hist;   // hist[0] is the newest sample
        logic [FILL_W-1:0]        fill;
        logic [IDX_W-1:0]         cnt;
        logic [OFS_W-1:0]         hold;
        logic                     vld;
        logic [BIP_W-1:0]         num;
        logic [BIP_W-1:0]         den;
        logic [IDX_W-1:0]         idx;
        logic [SMP_W-1:0]         amp;
    } st_t;

    st_t st_d, st_q;

    logic [IW-1:0]           nn, mm, dd;
    logic [BIP_W-1:0]        p0, p1, s0, s1;
    logic signed [BIP_W-1:0] b0, b1, dn;
    logic [SMP_W-1:0]        amp_c;
    logic                    ready, take;

    always_comb begin
        st_d = st_q;
        nn   = IW'(dly_i);
        mm   = IW'(ofs_i);
        // evaluation span: the later of the delayed successor and the amplitude tap
        dd   = ((nn + IW'(1)) >= mm) ? (nn + IW'(1)) : mm;

        // B in sixteenths: k*A[i] - 16*A[i+N], and the same one sample later
        p0 = BIP_W'(frac_i) * BIP_W'(st_q.hist[dd]);
        s0 = BIP_W'(st_q.hist[dd - nn]) << KFR_W;
        p1 = BIP_W'(frac_i) * BIP_W'(st_q.hist[dd - IW'(1)]);
        s1 = BIP_W'(st_q.hist[dd - IW'(1) - nn]) << KFR_W;
        b0 = $signed(p0 - s0);
        b1 = $signed(p1 - s1);
        dn = b0 - b1;
        amp_c = st_q.hist[dd - mm];

        ready = (st_q.fill > {1'b0, dd});
        take  = ready && (b0 > 0) && (b1 <= 0) && (amp_c > thr_i) && (st_q.hold == '0);

        st_d.hist = {st_q.hist[HD-2:0], a_i};
        st_d.cnt  = st_q.cnt + IDX_W'(1);
        if (st_q.fill != FILL_W'(HD)) begin
            st_d.fill = st_q.fill + FILL_W'(1);
        end

        if (take) begin
            st_d.hold = ofs_i;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - OFS_W'(1);
        end

        st_d.vld = take;
        st_d.num = take ? BIP_W'(b0) : '0;
        st_d.den = take ? BIP_W'(dn) : '0;
        st_d.idx = take ? (st_q.cnt - IDX_W'(1) - IDX_W'(dd)) : '0;
        st_d.amp = take ? amp_c : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign det_vld_o = st_q.vld;
    assign det_num_o = st_q.num;
    assign det_den_o = st_q.den;
    assign det_idx_o = st_q.idx;
    assign det_amp_o = st_q.amp;

    // a running hold-off window blocks the next detection
    p_holdoff_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.hold != '0) |=> !st_q.vld);

    // a registered crossing has a positive numerator not above its denominator
    p_crossing_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.vld |-> ((st_q.num != '0) && (st_q.den >= st_q.num)));
endmodule

// File: rtl/cfd_fine_div.sv
module cfd_fine_div #(
    parameter int unsigned BIP_W = cfd_pkg::BIP_W_DEF,
    parameter int unsigned FT_W  = cfd_pkg::FT_W_DEF,
    parameter int unsigned IDX_W = cfd_pkg::IDX_W_DEF,
    parameter int unsigned SMP_W = cfd_pkg::SMP_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_vld_i,
    input  logic [BIP_W-1:0] in_num_i,
    input  logic [BIP_W-1:0] in_den_i,
    input  logic [IDX_W-1:0] in_idx_i,
    input  logic [SMP_W-1:0] in_amp_i,
    output logic             out_vld_o,
    output logic [FT_W-1:0]  out_frac_o,
    output logic [IDX_W-1:0] out_idx_o,
    output logic [SMP_W-1:0] out_amp_o
);
    typedef struct packed {
        logic             vld;
        logic [BIP_W:0]   rem;
        logic [BIP_W-1:0] den;
        logic [FT_W-1:0]  quo;
        logic [IDX_W-1:0] idx;
        logic [SMP_W-1:0] amp;
    } stg_t;

    stg_t head;

    always_comb begin
        head     = '0;
        head.vld = in_vld_i;
        head.rem = {1'b0, in_num_i};
        head.den = in_den_i;
        head.idx = in_idx_i;
        head.amp = in_amp_i;
    end

    // one quotient bit per stage, so hits may follow each other every cycle
    for (genvar s = 0; s < FT_W; s++) begin : g_stg
        stg_t           src, stg_d, stg_q;
        logic [BIP_W:0] sh;

        if (s == 0) begin : g_head
            assign src = head;
        end else begin : g_link
            assign src = g_stg[s-1].stg_q;
        end

        always_comb begin
            stg_d = '0;
            sh    = {src.rem[BIP_W-1:0], 1'b0};
            if (src.vld) begin
                stg_d = src;
                if (sh >= {1'b0, src.den}) begin
                    stg_d.rem = sh - {1'b0, src.den};
                    stg_d.quo = FT_W'({src.quo, 1'b1});
                end else begin
                    stg_d.rem = sh;
                    stg_d.quo = FT_W'({src.quo, 1'b0});
                end
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stg_q <= '0;
            end else begin
                stg_q <= stg_d;
            end
        end

        // restoring step keeps the partial remainder within the divisor
        p_rem_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            stg_q.vld |-> (stg_q.rem <= {1'b0, stg_q.den}));
    end

    assign out_vld_o  = g_stg[FT_W-1].stg_q.vld;
    assign out_frac_o = g_stg[FT_W-1].stg_q.quo;
    assign out_idx_o  = g_stg[FT_W-1].stg_q.idx;
    assign out_amp_o  = g_stg[FT_W-1].stg_q.amp;
endmodule

// File: rtl/cfd_channel.sv
module cfd_channel #(
    parameter int unsigned SMP_W = cfd_pkg::SMP_W_DEF,
    parameter int unsigned KFR_W = cfd_pkg::KFR_W_DEF,
    parameter int unsigned BIP_W = cfd_pkg::BIP_W_DEF,
    parameter int unsigned FT_W  = cfd_pkg::FT_W_DEF,
    parameter int unsigned IDX_W = cfd_pkg::IDX_W_DEF,
    parameter int unsigned DLY_W = cfd_pkg::DLY_W_DEF,
    parameter int unsigned OFS_W = cfd_pkg::OFS_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SMP_W-1:0] smp_i,
    input  logic             spill_i,
    input  logic [SMP_W-1:0] ped_cfg_i,
    input  logic [KFR_W-1:0] frac_cfg_i,
    input  logic [DLY_W-1:0] dly_cfg_i,
    input  logic [OFS_W-1:0] ofs_cfg_i,
    input  logic [SMP_W-1:0] thr_cfg_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] coarse_o,
    output logic [FT_W-1:0]  fine_o,
    output logic [SMP_W-1:0] amp_o
);
    logic [SMP_W-1:0] net;
    logic             det_vld;
    logic [BIP_W-1:0] det_num, det_den;
    logic [IDX_W-1:0] det_idx;
    logic [SMP_W-1:0] det_amp;

    cfd_pedestal #(.SMP_W(SMP_W)) i_base (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .smp_i     (smp_i),
        .spill_i   (spill_i),
        .ped_cfg_i (ped_cfg_i),
        .net_o     (net)
    );

    cfd_detect #(
        .SMP_W(SMP_W), .KFR_W(KFR_W), .BIP_W(BIP_W),
        .IDX_W(IDX_W), .DLY_W(DLY_W), .OFS_W(OFS_W)
    ) i_det (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .a_i       (net),
        .frac_i    (frac_cfg_i),
        .dly_i     (dly_cfg_i),
        .ofs_i     (ofs_cfg_i),
        .thr_i     (thr_cfg_i),
        .det_vld_o (det_vld),
        .det_num_o (det_num),
        .det_den_o (det_den),
        .det_idx_o (det_idx),
        .det_amp_o (det_amp)
    );

    cfd_fine_div #(
        .BIP_W(BIP_W), .FT_W(FT_W), .IDX_W(IDX_W), .SMP_W(SMP_W)
    ) i_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .in_vld_i   (det_vld),
        .in_num_i   (det_num),
        .in_den_i   (det_den),
        .in_idx_i   (det_idx),
        .in_amp_i   (det_amp),
        .out_vld_o  (hit_o),
        .out_frac_o (fine_o),
        .out_idx_o  (coarse_o),
        .out_amp_o  (amp_o)
    );

    // a crossing needs B to fall, so it cannot rise again on the next sample
    p_hit_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |=> !hit_o);

    // amplitude must lie strictly above a non-negative threshold
    p_amp_above_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |-> (amp_o != '0));
endmodule

// File: tb/test_cfd_channel.sv
module test_cfd_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp = '0;
    logic        spill = 1'b0;
    logic        hit;
    logic [15:0] coarse;
    logic [3:0]  fine;
    logic [11:0] amp;

    int ped_c = 0, k_c = 8, n_c = 2, m_c = 1, thr_c = 20;

    always #4 clk = ~clk;

    cfd_channel i_cfd_channel (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .smp_i      (smp),
        .spill_i    (spill),
        .ped_cfg_i  (12'(ped_c)),
        .frac_cfg_i (4'(k_c)),
        .dly_cfg_i  (3'(n_c)),
        .ofs_cfg_i  (3'(m_c)),
        .thr_cfg_i  (12'(thr_c)),
        .hit_o      (hit),
        .coarse_o   (coarse),
        .fine_o     (fine),
        .amp_o      (amp)
    );

    int n_chk = 0, n_bad = 0, scen_hits = 0, seed = 7;
    string cur = "R10";

    typedef struct {bit h; int c; int f; int a;} rec_t;
    int   amem[8192];
    int   m_ped, m_e, m_hold;
    rec_t dl[6];
    int   shp[10] = '{0, 4, 12, 16, 11, 7, 6, 6, 5, 2};

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_ped = 0; m_e = 0; m_hold = 0;
        for (int q = 0; q < 6; q++) dl[q] = '{0, 0, 0, 0};
    endtask

    task automatic model_edge(int raw, bit sp);
        int a, d, i, b0, b1, ap, fr;
        rec_t r;
        a = (raw > m_ped) ? raw - m_ped : 0;
        amem[m_e & 8191] = a;
        if (sp) m_ped = ped_c;
        r = '{0, 0, 0, 0};
        d = (n_c + 1 >= m_c) ? n_c + 1 : m_c;
        if (m_e + 1 > d) begin
            i  = m_e - d;
            b0 = k_c * amem[i & 8191] - 16 * amem[(i + n_c) & 8191];
            b1 = k_c * amem[(i + 1) & 8191] - 16 * amem[(i + 1 + n_c) & 8191];
            ap = amem[(i + m_c) & 8191];
            if (b0 > 0 && b1 <= 0 && ap > thr_c && m_hold == 0) begin
                fr = (16 * b0) / (b0 - b1);
                if (fr > 15) fr = 15;
                r = '{1, i & 16'hFFFF, fr, ap};
            end
        end
        if (r.h) m_hold = m_c;
        else if (m_hold > 0) m_hold--;
        for (int q = 5; q > 0; q--) dl[q] = dl[q-1];
        dl[0] = r;
        m_e++;
    endtask

    task automatic tick(int raw, bit sp);
        if (raw > 4095) raw = 4095;
        if (raw < 0) raw = 0;
        smp = 12'(raw);
        spill = sp;
        @(posedge clk);
        model_edge(raw, sp);
        @(negedge clk);
        spill = 1'b0;
        if (hit) scen_hits++;
        check(cur, "hit", int'(hit), int'(dl[5].h));
        check("R8", "coarse", int'(coarse), dl[5].c);
        check("R4", "fine", int'(fine), dl[5].f);
        check("R5", "amp", int'(amp), dl[5].a);
    endtask

    function automatic int noise();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 3;
    endfunction

    task automatic idle(int base, int len);
        for (int q = 0; q < len; q++) tick(base + noise(), 0);
    endtask

    task automatic pulse(int base, int h, int gap);
        for (int q = 0; q < 10; q++) tick(base + (h * shp[q]) / 16 + noise(), 0);
        idle(base, gap);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        check("R10", "hit in reset", int'(hit), 0);
        check("R10", "coarse in reset", int'(coarse), 0);
        check("R10", "fine in reset", int'(fine), 0);
        check("R10", "amp in reset", int'(amp), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R10: reset state
        do_reset();

        // R9: a pulse right after reset, history still filling
        cur = "R9"; k_c = 15; n_c = 2; m_c = 1; thr_c = 20;
        for (int q = 0; q < 10; q++) tick(160 + 100 * shp[q], 0);
        idle(160, 10);

        // R3: baseline loaded, pulses of several heights
        cur = "R3"; scen_hits = 0;
        tick(160, 1'b0);
        ped_c = 100;
        tick(160, 1'b1);
        for (int h = 1; h <= 12; h++) pulse(160, 150 * h, 20);
        check("R3", "hits seen in pulse train", int'(scen_hits > 0), 1);

        // R5: threshold above every amplitude
        cur = "R5"; thr_c = 3000; scen_hits = 0;
        for (int h = 1; h <= 6; h++) pulse(160, 200 * h, 20);
        check("R5", "hits below threshold", scen_hits, 0);
        thr_c = 20;

        // R2: baseline value changed without a spill has no effect
        cur = "R2"; ped_c = 4000; scen_hits = 0;
        for (int h = 4; h <= 8; h++) pulse(160, 200 * h, 20);
        check("R2", "hits with unloaded baseline", int'(scen_hits > 0), 1);

        // R1: spill loads a baseline above all samples, everything clamps to zero
        cur = "R1";
        tick(160, 1'b1);
        idle(160, 12);
        scen_hits = 0;
        for (int h = 4; h <= 8; h++) pulse(160, 300, 20);
        check("R1", "hits on clamped stream", scen_hits, 0);
        ped_c = 100;
        tick(160, 1'b1);
        idle(160, 12);

        // R6: long hold-off, closely spaced double pulses
        cur = "R6"; n_c = 1; m_c = 6; k_c = 12;
        for (int h = 2; h <= 9; h++) begin
            pulse(160, 180 * h, 2 + (h % 4));
            pulse(160, 150 * h, 20);
        end

        // R7: span set by N, then span set by M
        cur = "R7"; n_c = 5; m_c = 2; k_c = 10;
        idle(160, 12);
        for (int h = 2; h <= 10; h++) pulse(160, 170 * h, 16);
        n_c = 0; m_c = 7; k_c = 14;
        idle(160, 12);
        for (int h = 2; h <= 10; h++) pulse(160, 170 * h, 16);

        // R4: sharp fall to baseline gives B[i+1] = 0 cases
        cur = "R4"; n_c = 1; m_c = 0; k_c = 15; thr_c = 5;
        idle(160, 12);
        for (int h = 1; h <= 8; h++) begin
            tick(160 + 400 * h, 0); tick(160 + 300 * h, 0); tick(160, 0);
            idle(160, 12);
        end

        // R8: run past the 16-bit index wrap
        cur = "R8"; n_c = 2; m_c = 1; k_c = 15; thr_c = 20;
        while (m_e < 66200) pulse(160, 900 + (m_e % 7) * 100, 30);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule